// File: doc/BRIEF.md
# Inverted Page Table Translator

This block maps a virtual address, tagged with the identifier of the process that issued it, to a physical address. It uses a single table with one slot per physical frame. Each slot records which process and which virtual page currently live in that frame. The frame number is not stored anywhere: it is the position of the slot that matches. The block returns that position joined with the unchanged page offset. If no slot holds the requested pair, it raises a fault.

Scanning every slot would take as many cycles as there are frames. To avoid this, an anchor table indexed by a hash of the process id and page number points at the most recently installed frame of that bucket. Every slot carries a link to the next frame with the same hash. A lookup follows this chain one slot per clock.

A write port installs a pair into a frame. Any mapping the frame held before is removed from its chain first, so the frame answers only for the new pair.

The controller has four states:
- IDLE accepts work.
  - A write goes to UNLINK when the frame sits behind another slot in its old chain.
  - A write goes to LINK when the frame is unused or heads its old chain. In the head case the anchor is repointed on the way.
  - A lookup goes to WALK when its bucket is occupied.
  - A lookup stays in IDLE and faults when the bucket is empty.
- WALK stays in WALK to hop to the next link. It returns to IDLE on a hit, at the end of the chain, or at the hop limit.
- UNLINK stays in UNLINK while it searches for the predecessor. It moves to LINK once the predecessor has been bypassed, or when the chain ends.
- LINK writes the slot, pushes it onto the head of its new bucket, and returns to IDLE.

Top module: `ipt_lookup`

## Requirements
- R1: After reset `ready` is 1, `rsp_valid` is 0 and no frame holds a mapping, so any lookup faults.
- R2: A lookup whose {pid, vpn} is held by frame i answers with `rsp_fault`=0 and `rsp_paddr` = {i, offset}. The frame index occupies the upper log2(FRAMES) bits and the request offset passes unchanged into the lower OFF_W bits.
- R3: A lookup matching no valid slot answers with `rsp_fault`=1 and `rsp_paddr` all zero.
- R4: The bucket of a pair is the XOR of all log2(FRAMES)-bit slices of the key {pid, vpn}, with pid in the upper bits and the key zero-padded at the top. Several mappings in one bucket all translate correctly, and the most recent install sits at the chain head.
- R5: A lookup is accepted on an edge where `ready`, `req_valid` and not `wr_valid` hold. An empty bucket answers right after that edge. Otherwise the slot at chain position k (head = 0) answers k+1 edges later, and a chain of n non-matching slots faults n edges later. `ready` stays low until the answer.
- R6: A slot matches only when both its pid and its vpn equal the request's. The same page of another process, or another page of the same process, faults.
- R7: Writing a new pair to a frame replaces its old pair. The old pair then faults and the new pair translates to that frame.
- R8: Removing a frame from the middle or head of a chain leaves the remaining slots reachable in the same order, each one position nearer the head.
- R9: An accepted write drops `ready` for at least one cycle. When the frame was unused or was its chain's head, it drops `ready` for exactly one cycle.
- R10: When `wr_valid` and `req_valid` are both high in an idle cycle, only the write is performed. The lookup is dropped and produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ready | output | 1 | Controller idle; a write or lookup is taken this cycle |
| wr_valid | input | 1 | Install request |
| wr_frame | input | log2(FRAMES) | Frame receiving the mapping |
| wr_pid | input | PID_W | Owning process id |
| wr_vpn | input | VPN_W | Virtual page number |
| req_valid | input | 1 | Lookup request |
| req_pid | input | PID_W | Requesting process id |
| req_vpn | input | VPN_W | Requested virtual page number |
| req_off | input | OFF_W | Offset within the page |
| rsp_valid | output | 1 | One-cycle pulse carrying the answer |
| rsp_fault | output | 1 | No mapping found |
| rsp_paddr | output | log2(FRAMES)+OFF_W | Physical address {frame, offset} |

## Verification
Every cycle, the checker confirms the following:
- Faults carry a valid pulse and a zero address.
- A successful answer carries the offset of the accepted request.
- A write never produces a response and always takes a busy cycle.
- An accepted lookup either answers at once or drops `ready`.
- No busy period outlasts a full-length chain walk.

Only the bench's scenarios can show which frame a pair resolves to, how chain position sets the answer latency, and that bucket collisions resolve. The same applies to rewrites, which must fault the old pair while leaving the rest of the chain reachable and one hop shorter.

// File: rtl/ipt_pkg.sv
package ipt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WALK,
        ST_UNLINK,
        ST_LINK
    } ipt_state_e;
endpackage

// File: rtl/ipt_hash.sv
module ipt_hash #(
    parameter int PID_W = 8,
    parameter int VPN_W = 20,
    parameter int H_W   = 6
) (
    input  logic [PID_W-1:0] pid,
    input  logic [VPN_W-1:0] vpn,
    output logic [H_W-1:0]   bucket
);
    localparam int KEY_W  = PID_W + VPN_W;
    localparam int SLICES = (KEY_W + H_W - 1) / H_W;

    logic [SLICES*H_W-1:0] key_pad;

    assign key_pad = {{(SLICES*H_W-KEY_W){1'b0}}, pid, vpn};

    always_comb begin
        bucket = '0;
        for (int s = 0; s < SLICES; s++) begin
            bucket = bucket ^ key_pad[s*H_W +: H_W];
        end
    end
endmodule

// File: rtl/ipt_anchor_store.sv
module ipt_anchor_store #(
    parameter int FRAMES = 64,
    parameter int IDX_W  = $clog2(FRAMES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] bkt,
    output logic             rd_vld,
    output logic [IDX_W-1:0] rd_idx,
    input  logic             we,
    input  logic             w_vld,
    input  logic [IDX_W-1:0] w_idx
);
    logic             vld_m [FRAMES];
    logic [IDX_W-1:0] idx_m [FRAMES];

    assign rd_vld = vld_m[bkt];
    assign rd_idx = idx_m[bkt];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int b = 0; b < FRAMES; b++) vld_m[b] <= 1'b0;
        end else if (we) begin
            vld_m[bkt] <= w_vld;
        end
    end

    always_ff @(posedge clk) begin
        if (we) idx_m[bkt] <= w_idx;
    end
endmodule

// File: rtl/ipt_frame_store.sv
module ipt_frame_store #(
    parameter int FRAMES = 64,
    parameter int PID_W  = 8,
    parameter int VPN_W  = 20,
    parameter int IDX_W  = $clog2(FRAMES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] a_addr,
    output logic             a_vld,
    output logic [PID_W-1:0] a_pid,
    output logic [VPN_W-1:0] a_vpn,
    output logic             a_nv,
    output logic [IDX_W-1:0] a_nx,
    input  logic [IDX_W-1:0] b_addr,
    output logic             b_vld,
    output logic [PID_W-1:0] b_pid,
    output logic [VPN_W-1:0] b_vpn,
    output logic             b_nv,
    output logic [IDX_W-1:0] b_nx,
    input  logic             key_en,
    input  logic             lnk_en,
    input  logic [IDX_W-1:0] w_addr,
    input  logic             w_vld,
    input  logic [PID_W-1:0] w_pid,
    input  logic [VPN_W-1:0] w_vpn,
    input  logic             w_nv,
    input  logic [IDX_W-1:0] w_nx
);
    logic             vld_m [FRAMES];
    logic [PID_W-1:0] pid_m [FRAMES];
    logic [VPN_W-1:0] vpn_m [FRAMES];
    logic             nv_m  [FRAMES];
    logic [IDX_W-1:0] nx_m  [FRAMES];

    assign a_vld = vld_m[a_addr];
    assign a_pid = pid_m[a_addr];
    assign a_vpn = vpn_m[a_addr];
    assign a_nv  = nv_m[a_addr];
    assign a_nx  = nx_m[a_addr];
    assign b_vld = vld_m[b_addr];
    assign b_pid = pid_m[b_addr];
    assign b_vpn = vpn_m[b_addr];
    assign b_nv  = nv_m[b_addr];
    assign b_nx  = nx_m[b_addr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int f = 0; f < FRAMES; f++) begin
                vld_m[f] <= 1'b0;
                nv_m[f]  <= 1'b0;
            end
        end else begin
            if (key_en) vld_m[w_addr] <= w_vld;
            if (lnk_en) nv_m[w_addr]  <= w_nv;
        end
    end

    always_ff @(posedge clk) begin
        if (key_en) begin
            pid_m[w_addr] <= w_pid;
            vpn_m[w_addr] <= w_vpn;
        end
        if (lnk_en) nx_m[w_addr] <= w_nx;
    end
endmodule

// File: rtl/ipt_lookup.sv
module ipt_lookup
    import ipt_pkg::*;
#(
    parameter int  FRAMES = 64,
    parameter int  PID_W  = 8,
    parameter int  VPN_W  = 20,
    parameter int  OFF_W  = 12,
    localparam int IDX_W  = $clog2(FRAMES),
    localparam int PA_W   = IDX_W + OFF_W
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             ready,
    input  logic             wr_valid,
    input  logic [IDX_W-1:0] wr_frame,
    input  logic [PID_W-1:0] wr_pid,
    input  logic [VPN_W-1:0] wr_vpn,
    input  logic             req_valid,
    input  logic [PID_W-1:0] req_pid,
    input  logic [VPN_W-1:0] req_vpn,
    input  logic [OFF_W-1:0] req_off,
    output logic             rsp_valid,
    output logic             rsp_fault,
    output logic [PA_W-1:0]  rsp_paddr
);
    localparam logic [IDX_W:0] HOP_LIM = (IDX_W+1)'(FRAMES);

    ipt_state_e       st_q, st_d;
    logic [IDX_W-1:0] frm_q, cur_q;
    logic [PID_W-1:0] pid_q;
    logic [VPN_W-1:0] vpn_q;
    logic [OFF_W-1:0] off_q;
    logic [IDX_W:0]   hop_q;

    logic [PID_W-1:0] hk_pid;
    logic [VPN_W-1:0] hk_vpn;
    logic [IDX_W-1:0] bkt;
    logic             an_vld, an_we, an_wvld;
    logic [IDX_W-1:0] an_idx, an_widx;

    logic [IDX_W-1:0] fa_addr, fa_nx, fb_nx, fw_addr, fw_nx;
    logic             fa_vld, fa_nv, fb_vld, fb_nv;
    logic [PID_W-1:0] fa_pid, fb_pid, fw_pid;
    logic [VPN_W-1:0] fa_vpn, fb_vpn, fw_vpn;
    logic             fk_en, fn_en, fw_vld, fw_nv;

    logic take_wr, take_rd, walk_hit, chain_stop;

    assign ready      = (st_q == ST_IDLE);
    assign take_wr    = ready && wr_valid;
    assign take_rd    = ready && !wr_valid && req_valid;
    assign fa_addr    = ready ? wr_frame : frm_q;
    assign walk_hit   = fb_vld && (fb_pid == pid_q) && (fb_vpn == vpn_q);
    assign chain_stop = !fb_nv || (hop_q >= HOP_LIM);

    // Key fed to the shared hash: old pair of the frame being rewritten,
    // incoming lookup key, or the registered key while linking.
    always_comb begin
        if (take_wr) begin
            hk_pid = fa_pid;
            hk_vpn = fa_vpn;
        end else if (ready) begin
            hk_pid = req_pid;
            hk_vpn = req_vpn;
        end else begin
            hk_pid = pid_q;
            hk_vpn = vpn_q;
        end
    end

    ipt_hash #(.PID_W(PID_W), .VPN_W(VPN_W), .H_W(IDX_W)) u_hash (
        .pid(hk_pid), .vpn(hk_vpn), .bucket(bkt)
    );

    ipt_anchor_store #(.FRAMES(FRAMES), .IDX_W(IDX_W)) u_anchor (
        .clk(clk), .rst_n(rst_n), .bkt(bkt),
        .rd_vld(an_vld), .rd_idx(an_idx),
        .we(an_we), .w_vld(an_wvld), .w_idx(an_widx)
    );

    ipt_frame_store #(.FRAMES(FRAMES), .PID_W(PID_W), .VPN_W(VPN_W), .IDX_W(IDX_W)) u_frames (
        .clk(clk), .rst_n(rst_n),
        .a_addr(fa_addr), .a_vld(fa_vld), .a_pid(fa_pid), .a_vpn(fa_vpn), .a_nv(fa_nv), .a_nx(fa_nx),
        .b_addr(cur_q), .b_vld(fb_vld), .b_pid(fb_pid), .b_vpn(fb_vpn), .b_nv(fb_nv), .b_nx(fb_nx),
        .key_en(fk_en), .lnk_en(fn_en), .w_addr(fw_addr), .w_vld(fw_vld),
        .w_pid(fw_pid), .w_vpn(fw_vpn), .w_nv(fw_nv), .w_nx(fw_nx)
    );

    // Next state and table write controls
    always_comb begin
        st_d    = st_q;
        an_we   = 1'b0;
        an_wvld = 1'b0;
        an_widx = '0;
        fk_en   = 1'b0;
        fn_en   = 1'b0;
        fw_addr = frm_q;
        fw_vld  = 1'b0;
        fw_pid  = pid_q;
        fw_vpn  = vpn_q;
        fw_nv   = 1'b0;
        fw_nx   = '0;
        unique case (st_q)
            ST_IDLE: begin
                if (take_wr) begin
                    fk_en   = 1'b1;
                    fw_addr = wr_frame;
                    if (!fa_vld || !an_vld) begin
                        st_d = ST_LINK;
                    end else if (an_idx == wr_frame) begin
                        an_we   = 1'b1;
                        an_wvld = fa_nv;
                        an_widx = fa_nx;
                        st_d    = ST_LINK;
                    end else begin
                        st_d = ST_UNLINK;
                    end
                end else if (take_rd && an_vld) begin
                    st_d = ST_WALK;
                end
            end
            ST_WALK: begin
                if (walk_hit || chain_stop) st_d = ST_IDLE;
            end
            ST_UNLINK: begin
                if (fb_nv && (fb_nx == frm_q)) begin
                    fn_en   = 1'b1;
                    fw_addr = cur_q;
                    fw_nv   = fa_nv;
                    fw_nx   = fa_nx;
                    st_d    = ST_LINK;
                end else if (chain_stop) begin
                    st_d = ST_LINK;
                end
            end
            ST_LINK: begin
                fk_en   = 1'b1;
                fn_en   = 1'b1;
                fw_vld  = 1'b1;
                fw_nv   = an_vld;
                fw_nx   = an_idx;
                an_we   = 1'b1;
                an_wvld = 1'b1;
                an_widx = frm_q;
                st_d    = ST_IDLE;
            end
        endcase
    end

    // State register and walk context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            frm_q <= '0;
            cur_q <= '0;
            pid_q <= '0;
            vpn_q <= '0;
            off_q <= '0;
            hop_q <= '0;
        end else begin
            st_q <= st_d;
            if (take_wr) begin
                frm_q <= wr_frame;
                pid_q <= wr_pid;
                vpn_q <= wr_vpn;
                cur_q <= an_idx;
                hop_q <= '0;
            end else if (take_rd) begin
                pid_q <= req_pid;
                vpn_q <= req_vpn;
                off_q <= req_off;
                cur_q <= an_idx;
                hop_q <= '0;
            end else if (st_q == ST_WALK || st_q == ST_UNLINK) begin
                cur_q <= fb_nx;
                hop_q <= hop_q + 1'b1;
            end
        end
    end

    // Response outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_paddr <= '0;
        end else begin
            rsp_valid <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_paddr <= '0;
            if (take_rd && !an_vld) begin
                rsp_valid <= 1'b1;
                rsp_fault <= 1'b1;
            end else if (st_q == ST_WALK) begin
                if (walk_hit) begin
                    rsp_valid <= 1'b1;
                    rsp_paddr <= {cur_q, off_q};
                end else if (chain_stop) begin
                    rsp_valid <= 1'b1;
                    rsp_fault <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/ipt_lookup_chk.sv
module ipt_lookup_chk #(
    parameter int FRAMES = 64,
    parameter int OFF_W  = 12,
    parameter int PA_W   = 18
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ready,
    input logic             wr_valid,
    input logic             req_valid,
    input logic [OFF_W-1:0] req_off,
    input logic             rsp_valid,
    input logic             rsp_fault,
    input logic [PA_W-1:0]  rsp_paddr
);
    localparam int BUSY_MAX = 2 * FRAMES + 4;

    logic [OFF_W-1:0] off_cap;
    logic [15:0]      busy_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_cap  <= '0;
            busy_cnt <= '0;
        end else begin
            if (ready && !wr_valid && req_valid) off_cap <= req_off;
            busy_cnt <= ready ? 16'd0 : busy_cnt + 16'd1;
        end
    end

    assert_fault_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> rsp_valid);

    assert_fault_addr_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_paddr == '0));

    assert_offset_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> (rsp_paddr[OFF_W-1:0] == off_cap));

    assert_write_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && wr_valid) |=> !ready);

    assert_write_no_rsp_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && wr_valid) |=> !rsp_valid);

    assert_lookup_progress_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !wr_valid && req_valid) |=> (rsp_valid || !ready));

    assert_busy_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy_cnt <= 16'(BUSY_MAX));
endmodule

bind ipt_lookup ipt_lookup_chk #(.FRAMES(FRAMES), .OFF_W(OFF_W), .PA_W(PA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ready(ready), .wr_valid(wr_valid),
    .req_valid(req_valid), .req_off(req_off), .rsp_valid(rsp_valid),
    .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr)
);

// File: tb/tb_ipt_lookup.sv
`timescale 1ns/1ps
module tb_ipt_lookup;
    localparam int FRAMES = 64;
    localparam int PID_W  = 8;
    localparam int VPN_W  = 20;
    localparam int OFF_W  = 12;
    localparam int IDX_W  = 6;
    localparam int PA_W   = IDX_W + OFF_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ready;
    logic             wr_valid = 1'b0;
    logic [IDX_W-1:0] wr_frame = '0;
    logic [PID_W-1:0] wr_pid = '0;
    logic [VPN_W-1:0] wr_vpn = '0;
    logic             req_valid = 1'b0;
    logic [PID_W-1:0] req_pid = '0;
    logic [VPN_W-1:0] req_vpn = '0;
    logic [OFF_W-1:0] req_off = '0;
    logic             rsp_valid;
    logic             rsp_fault;
    logic [PA_W-1:0]  rsp_paddr;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    ipt_lookup #(.FRAMES(FRAMES), .PID_W(PID_W), .VPN_W(VPN_W), .OFF_W(OFF_W)) dut (
        .clk(clk), .rst_n(rst_n), .ready(ready),
        .wr_valid(wr_valid), .wr_frame(wr_frame), .wr_pid(wr_pid), .wr_vpn(wr_vpn),
        .req_valid(req_valid), .req_pid(req_pid), .req_vpn(req_vpn), .req_off(req_off),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr)
    );

    typedef struct packed {
        logic [7:0]  pid;
        logic [19:0] vpn;
        logic [11:0] off;
        logic        flt;
        logic [5:0]  frame;
        logic [3:0]  lat;
        logic [3:0]  rq;
    } vec_t;

    // Bucket 0x14 chain after setup: frame 9 (head), frame 7, frame 3.
    localparam vec_t VECS [9] = '{
        '{8'h01, 20'h00010, 12'hABC, 1'b0, 6'd3,  4'd3, 4'd4},
        '{8'h01, 20'h00051, 12'h001, 1'b0, 6'd7,  4'd2, 4'd4},
        '{8'h01, 20'h01011, 12'hFFF, 1'b0, 6'd9,  4'd1, 4'd4},
        '{8'h02, 20'h00010, 12'h123, 1'b0, 6'd20, 4'd1, 4'd2},
        '{8'hFF, 20'hFFFFF, 12'h555, 1'b0, 6'd63, 4'd1, 4'd2},
        '{8'h00, 20'h00000, 12'h000, 1'b0, 6'd0,  4'd1, 4'd2},
        '{8'h40, 20'h00010, 12'h007, 1'b1, 6'd0,  4'd3, 4'd6},
        '{8'h01, 20'h02012, 12'h008, 1'b1, 6'd0,  4'd3, 4'd6},
        '{8'h00, 20'h00003, 12'h009, 1'b1, 6'd0,  4'd0, 4'd3}
    };

    function automatic string tag_of(input logic [3:0] n);
        case (n)
            4'd2:    return "R2";
            4'd3:    return "R3";
            4'd4:    return "R4";
            4'd6:    return "R6";
            default: return "R5";
        endcase
    endfunction

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic do_write(input int fr, input int pid, input int vpn, output int busy);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_frame = IDX_W'(fr);
        wr_pid   = PID_W'(pid);
        wr_vpn   = VPN_W'(vpn);
        @(posedge clk);
        @(negedge clk);
        wr_valid = 1'b0;
        busy = 0;
        while (!ready && busy < 1000) begin
            busy++;
            @(negedge clk);
        end
    endtask

    task automatic do_lookup(input int pid, input int vpn, input int off,
                             output logic flt, output logic [PA_W-1:0] pa, output int lat);
        @(negedge clk);
        req_valid = 1'b1;
        req_pid   = PID_W'(pid);
        req_vpn   = VPN_W'(vpn);
        req_off   = OFF_W'(off);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 0;
        while (!rsp_valid && lat < 1000) begin
            lat++;
            @(negedge clk);
        end
        flt = rsp_valid ? rsp_fault : 1'b1;
        pa  = rsp_paddr;
        while (!ready) @(negedge clk);
    endtask

    task automatic expect_hit(input string tag, input int pid, input int vpn, input int off,
                              input int frame, input int exp_lat);
        logic            f;
        logic [PA_W-1:0] p;
        int              l;
        do_lookup(pid, vpn, off, f, p, l);
        chk(tag, "fault flag on hit", f, 0);
        chk(tag, "physical address", p, {IDX_W'(frame), OFF_W'(off)});
        if (exp_lat >= 0) chk("R5", "hit latency", l, exp_lat);
    endtask

    task automatic expect_fault(input string tag, input int pid, input int vpn);
        logic            f;
        logic [PA_W-1:0] p;
        int              l;
        do_lookup(pid, vpn, 12'h3C3, f, p, l);
        chk(tag, "fault flag on miss", f, 1);
        chk("R3", "fault address zero", p, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R5 watchdog expired: actual hung expected finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int busy;
        bit seen;
        logic            f;
        logic [PA_W-1:0] p;
        int              l;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1", "ready after reset", ready, 1);
        chk("R1", "rsp_valid after reset", rsp_valid, 0);
        expect_fault("R1", 1, 20'h00010);

        // R9: write to an unused frame busies the block exactly one cycle
        do_write(3, 1, 20'h00010, busy);
        chk("R9", "busy cycles, unused frame", busy, 1);

        // R10: simultaneous write and lookup; lookup of a mapped pair must vanish
        @(negedge clk);
        wr_valid = 1'b1; wr_frame = 6'd7; wr_pid = 8'h01; wr_vpn = 20'h00051;
        req_valid = 1'b1; req_pid = 8'h01; req_vpn = 20'h00010; req_off = 12'h111;
        @(posedge clk);
        @(negedge clk);
        wr_valid = 1'b0;
        req_valid = 1'b0;
        chk("R10", "ready low after simultaneous request", ready, 0);
        seen = 1'b0;
        for (int c = 0; c < 6; c++) begin
            if (rsp_valid) seen = 1'b1;
            @(negedge clk);
        end
        chk("R10", "dropped lookup produced a response", seen, 0);

        do_write(9,  8'h01, 20'h01011, busy);
        do_write(20, 8'h02, 20'h00010, busy);
        do_write(63, 8'hFF, 20'hFFFFF, busy);
        do_write(0,  8'h00, 20'h00000, busy);

        // Table of lookups: R2, R3, R4, R5, R6
        for (int v = 0; v < 9; v++) begin
            do_lookup(VECS[v].pid, VECS[v].vpn, VECS[v].off, f, p, l);
            chk(tag_of(VECS[v].rq), "fault flag", f, VECS[v].flt);
            if (!VECS[v].flt) chk(tag_of(VECS[v].rq), "physical address", p, {VECS[v].frame, VECS[v].off});
            else              chk("R3", "fault address zero", p, 0);
            chk("R5", "response latency", l, VECS[v].lat);
        end

        // R7 / R8: rewrite frame 7 from the middle of the chain
        do_write(7, 8'h04, 20'h00777, busy);
        chk("R9", "busy at least one cycle, mid-chain frame", (busy >= 1), 1);
        expect_fault("R7", 8'h01, 20'h00051);
        expect_hit("R7", 8'h04, 20'h00777, 12'h0A5, 7, 1);
        expect_hit("R8", 8'h01, 20'h00010, 12'h5A0, 3, 2);
        expect_hit("R8", 8'h01, 20'h01011, 12'h00F, 9, 1);

        // R7 / R8 / R9: rewrite the chain head, frame 9
        do_write(9, 8'h03, 20'h00020, busy);
        chk("R9", "busy cycles, chain head frame", busy, 1);
        expect_fault("R7", 8'h01, 20'h01011);
        expect_hit("R7", 8'h03, 20'h00020, 12'h777, 9, 1);
        expect_hit("R8", 8'h01, 20'h00010, 12'h246, 3, 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule